// File: doc/BRIEF.md
# Single-Register MDIO Management Master

This block runs clause 22 management transactions on an MDC/MDIO pair. It has one 32-bit command/status word. Software writes the target PHY number, the register number, the write data, the direction, an enable flag and a busy flag in a single store. The block then shifts the whole frame onto the wire. When the frame is over it drops busy. For a read, it also puts the 16 bits it returned into the low half of that same word, in place of the write data.

MDC comes from the system clock through an even divider. MDIO is driven as a data bit plus an output enable, so that a pad or tri-state buffer can sit outside the block. A command is only accepted for PHY numbers below a parameterised population count. A command for any other PHY, or one missing its enable or busy flag, is stored but starts nothing.

The frame engine uses seven states:
- `ST_IDLE` goes to `ST_ARM` when a command is accepted.
- `ST_ARM` goes to `ST_PRE` at the next MDC falling point.
- `ST_PRE` sends 32 ones and then goes to `ST_HEAD`.
- `ST_HEAD` sends 14 bits (start, opcode, PHY, register) and then goes to `ST_TURN`.
- `ST_TURN` takes 2 bits and then goes to `ST_DATA`.
- `ST_DATA` takes 16 bits and then goes to `ST_GAP`.
- `ST_GAP` holds MDIO released for one MDC period and then returns to `ST_IDLE`. This transition is where busy is cleared.

Top module: `mdio_ctl_master`

## Requirements
- R1: After reset the command/status word reads all zeros, MDC is low and the MDIO output enable is low.
- R2: MDC has a period of MDC_DIV system clocks: MDC_DIV/2 cycles high and MDC_DIV/2 cycles low.
- R3: A write while idle with bit 31 (busy) and bit 30 (enable) set and a PHY number in bits 25:21 below NUM_PHY sets busy in the next cycle and starts a frame.
- R4: A write while idle whose PHY number in bits 25:21 is NUM_PHY or more leaves busy clear and produces no frame. The word then reads back the written bits 30, 27 and 25:0, with bits 31, 29, 28 and 26 reading as zero.
- R5: A write while idle with bit 30 clear or bit 31 clear leaves busy clear and produces no frame.
- R6: A write frame (bit 27 clear) sends these 64 bits, MSB first, with MDIO enabled throughout:
  - 32 ones
  - 01 (start)
  - 01 (write opcode)
  - PHY number, 5 bits
  - register number from bits 20:16, 5 bits
  - 10 (turnaround)
  - data from bits 15:0, 16 bits
- R7: A read frame (bit 27 set) drives 32 ones, 01, 10, the PHY number and the register number. It then releases MDIO for the 2 turnaround bits and the 16 data bits. It samples the data MSB first on the rising MDC points and places it in bits 15:0.
- R8: Busy clears when the frame ends, and MDIO is never enabled while busy is clear. A write frame leaves bits 30, 27 and 25:0 as written.
- R9: Writes while busy are ignored. This includes a write in the very cycle that busy clears, which leaves the read result visible. The next write after that is accepted.
- R10: The MDIO data and output enable change only at the points where MDC falls.
- R11: Between two frames MDIO stays released for at least one full MDC period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Store strobe for the command/status word |
| csr_wdata | input | 32 | Value stored with csr_wr |
| csr_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
The collision of interest is a software write that arrives in the same cycle as the end of a frame: the engine clears busy and loads the read result while the store strobe is still being evaluated against the old busy flag. The bench provokes it during a read frame by holding the store strobe high on every cycle with a second, non-starting command. It judges the outcome cycle by cycle. The first cycle after busy falls must show the PHY model's arithmetic read value. The cycle after that must show the second command's fields.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_LEN  = 32;
    localparam int HEAD_LEN = 14;
    localparam int TURN_LEN = 2;
    localparam int SHIFT_W  = 32;

    localparam int BUSY_BIT = 31;
    localparam int EN_BIT   = 30;
    localparam int RD_BIT   = 27;
    localparam int PHY_LSB  = 21;
    localparam int REG_LSB  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PRE,
        ST_HEAD,
        ST_TURN,
        ST_DATA,
        ST_GAP
    } eng_state_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int MDC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int HALF = MDC_DIV / 2;
    localparam int CW   = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc       = mdc_q;
    assign tick_rise = wrap & ~mdc_q;
    assign tick_fall = wrap & mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdat,
    input  logic              tick_rise,
    input  logic              tick_fall,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdat,
    output logic              done
);
    eng_state_t         st_q, st_nxt;
    logic [4:0]         cnt_q;
    logic [SHIFT_W-1:0] sh_q;
    logic               rd_q;
    logic               shift_en;

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_nxt = ST_ARM;
            ST_ARM:  if (tick_fall) st_nxt = ST_PRE;
            ST_PRE:  if (tick_fall && cnt_q == 5'(PRE_LEN - 1))  st_nxt = ST_HEAD;
            ST_HEAD: if (tick_fall && cnt_q == 5'(HEAD_LEN - 1)) st_nxt = ST_TURN;
            ST_TURN: if (tick_fall && cnt_q == 5'(TURN_LEN - 1)) st_nxt = ST_DATA;
            ST_DATA: if (tick_fall && cnt_q == 5'(DATA_W - 1))   st_nxt = ST_GAP;
            ST_GAP:  if (tick_fall) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign shift_en = tick_fall &&
        ((st_q == ST_PRE && st_nxt == ST_HEAD) || st_q == ST_HEAD ||
         st_q == ST_TURN || (st_q == ST_DATA && st_nxt == ST_DATA));

    // state register, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
            rd_q  <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_nxt != st_q)
                cnt_q <= '0;
            else if (tick_fall)
                cnt_q <= cnt_q + 1'b1;
            if (st_q == ST_IDLE && start) begin
                sh_q <= {2'b01, (rd ? 2'b10 : 2'b01), phy, regad, 2'b10, wdat};
                rd_q <= rd;
            end else if (shift_en) begin
                sh_q <= sh_q << 1;
            end
        end
    end

    // pin outputs and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            rdat    <= '0;
        end else begin
            if (tick_fall) begin
                unique case (st_nxt)
                    ST_PRE: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                    ST_HEAD: begin
                        mdio_o  <= sh_q[SHIFT_W-1];
                        mdio_oe <= 1'b1;
                    end
                    ST_TURN, ST_DATA: begin
                        mdio_o  <= rd_q ? 1'b0 : sh_q[SHIFT_W-1];
                        mdio_oe <= ~rd_q;
                    end
                    default: begin
                        mdio_o  <= 1'b0;
                        mdio_oe <= 1'b0;
                    end
                endcase
            end
            if (st_q == ST_IDLE && start)
                rdat <= '0;
            else if (tick_rise && st_q == ST_DATA && rd_q)
                rdat <= {rdat[DATA_W-2:0], mdio_i};
        end
    end

    assign done = (st_q == ST_GAP) && tick_fall;
endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
    import mdio_ctl_pkg::*;
#(
    parameter int NUM_PHY = 5,
    parameter int MDC_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int unsigned PHY_LIMIT = NUM_PHY;

    logic              busy_q, en_q, rd_q;
    logic [ADDR_W-1:0] phy_q, reg_q;
    logic [DATA_W-1:0] data_q;
    logic              accept, phy_ok, go;
    logic              tick_rise, tick_fall, eng_done;
    logic [DATA_W-1:0] eng_rdat;

    assign accept = csr_wr & ~busy_q;
    assign phy_ok = (32'(csr_wdata[PHY_LSB +: ADDR_W]) < PHY_LIMIT);
    assign go     = accept & csr_wdata[BUSY_BIT] & csr_wdata[EN_BIT] & phy_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            en_q   <= 1'b0;
            rd_q   <= 1'b0;
            phy_q  <= '0;
            reg_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            busy_q <= go;
            en_q   <= csr_wdata[EN_BIT];
            rd_q   <= csr_wdata[RD_BIT];
            phy_q  <= csr_wdata[PHY_LSB +: ADDR_W];
            reg_q  <= csr_wdata[REG_LSB +: ADDR_W];
            data_q <= csr_wdata[DATA_W-1:0];
        end else if (eng_done) begin
            busy_q <= 1'b0;
            if (rd_q)
                data_q <= eng_rdat;
        end
    end

    assign csr_rdata = {busy_q, en_q, 2'b00, rd_q, 1'b0, phy_q, reg_q, data_q};

    mdio_clk_div #(.MDC_DIV(MDC_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    mdio_frame_eng u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .rd        (csr_wdata[RD_BIT]),
        .phy       (csr_wdata[PHY_LSB +: ADDR_W]),
        .regad     (csr_wdata[REG_LSB +: ADDR_W]),
        .wdat      (csr_wdata[DATA_W-1:0]),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdat      (eng_rdat),
        .done      (eng_done)
    );
endmodule

// File: rtl/mdio_ctl_master_chk.sv
module mdio_ctl_master_chk #(
    parameter int NUM_PHY = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_wr,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        eng_done
);
    logic busy, phy_in_range;
    assign busy         = csr_rdata[31];
    assign phy_in_range = (32'(csr_wdata[25:21]) < 32'(NUM_PHY));

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && !busy && csr_wdata[31] && csr_wdata[30] && phy_in_range |=> busy);

    // R4
    bad_phy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && !busy && !phy_in_range |=> !busy);

    // R5
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && !busy && (!csr_wdata[30] || !csr_wdata[31]) |=> !busy);

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy);

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && busy && !eng_done |=> $stable(csr_rdata));

    // R10
    oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> !mdc);

    // R10
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);
endmodule

bind mdio_ctl_master mdio_ctl_master_chk #(.NUM_PHY(NUM_PHY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .eng_done  (eng_done)
);

// File: tb/mdio_ctl_master_test.sv
module mdio_ctl_master_test;
    localparam int CLK_P   = 10;
    localparam int MDC_DIV = 4;
    localparam int NUM_PHY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int errors = 0;

    mdio_ctl_master #(.NUM_PHY(NUM_PHY), .MDC_DIV(MDC_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_P/2) clk = ~clk;

    // frame monitor and PHY model
    logic        in_frame = 1'b0;
    int          pos = 0;
    int          frames = 0;
    int          idle_rises = 0;
    int          gap_bad = 0;
    logic [63:0] cap_o = '0, cap_oe = '0;
    logic        cur_rd = 1'b0;
    logic [15:0] rd_val = '0;

    always @(posedge mdc) begin
        if (!in_frame && mdio_oe) begin
            if (frames > 0 && idle_rises < 1) gap_bad++;
            in_frame = 1'b1;
            cap_o[63] = mdio_o;
            cap_oe[63] = mdio_oe;
            pos = 1;
        end else if (in_frame) begin
            cap_o[63-pos] = mdio_o;
            cap_oe[63-pos] = mdio_oe;
            pos++;
            if (pos == 64) begin
                in_frame = 1'b0;
                frames++;
                idle_rises = 0;
            end
        end else begin
            idle_rises++;
        end
    end

    always_comb begin
        if (cur_rd && in_frame && pos >= 48 && pos < 64)
            mdio_i = rd_val[(63 - pos) & 15];
        else
            mdio_i = 1'b1;
    end

    function automatic logic [15:0] phy_val(input int p, input int r);
        return 16'(p * 16'h0841) ^ 16'(r * 16'h0111) ^ 16'h5A3C;
    endfunction

    function automatic logic [31:0] mk_cmd(input bit b, input bit en, input bit rd,
                                           input int p, input int r, input logic [15:0] d);
        return {b, en, 2'b00, rd, 1'b0, 5'(p), 5'(r), d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && csr_rdata[31]; n++) @(negedge clk);
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = w;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic run_frame(input bit rd, input int p, input int r, input logic [15:0] d);
        int f0;
        logic [63:0] exp;
        f0 = frames;
        cur_rd = rd;
        rd_val = phy_val(p, r);
        issue(mk_cmd(1, 1, rd, p, r, d));
        chk(csr_rdata[31] == 1'b1, "R3", 64'(csr_rdata), 64'(mk_cmd(1, 1, rd, p, r, d)));
        wait_idle();
        chk(frames == f0 + 1, "R3", 64'(frames), 64'(f0 + 1));
        if (!rd) begin
            exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(p), 5'(r), 2'b10, d};
            chk(cap_o == exp && cap_oe == '1, "R6", cap_o, exp);
            chk(csr_rdata == mk_cmd(0, 1, 0, p, r, d), "R8",
                64'(csr_rdata), 64'(mk_cmd(0, 1, 0, p, r, d)));
        end else begin
            exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(p), 5'(r), 18'd0};
            chk(cap_o[63:18] == exp[63:18], "R7", cap_o, exp);
            chk(cap_oe == {46'h3FFF_FFFF_FFFF, 18'd0}, "R7", cap_oe,
                {46'h3FFF_FFFF_FFFF, 18'd0});
            chk(csr_rdata == mk_cmd(0, 1, 1, p, r, phy_val(p, r)), "R7",
                64'(csr_rdata), 64'(mk_cmd(0, 1, 1, p, r, phy_val(p, r))));
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        time t0, t1, t2;
        int f0;
        logic [31:0] w, snap, b_cmd;
        #(CLK_P * 3 + 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(csr_rdata == 32'd0 && !mdio_oe && !mdc, "R1",
            {csr_rdata, 30'd0, mdio_oe, mdc}, 64'd0);

        // R2: MDC period and duty
        @(posedge mdc); t0 = $time;
        @(negedge mdc); t1 = $time;
        @(posedge mdc); t2 = $time;
        chk((t2 - t0) == MDC_DIV * CLK_P, "R2", 64'(t2 - t0), 64'(MDC_DIV * CLK_P));
        chk((t1 - t0) == (MDC_DIV / 2) * CLK_P, "R2", 64'(t1 - t0), 64'((MDC_DIV / 2) * CLK_P));

        // R3 R6 R8: write sweep over every populated PHY
        for (int p = 0; p < NUM_PHY; p++)
            for (int k = 0; k < 3; k++)
                run_frame(0, p, (p * 7 + k * 11) % 32, 16'(p * 16'h03C5 + k * 16'h09A1) ^ 16'hF00F);

        // R7: read sweep
        for (int p = 0; p < NUM_PHY; p++)
            for (int k = 0; k < 2; k++)
                run_frame(1, p, (p * 5 + k * 13 + 3) % 32, 16'h1234);

        // R11: idle gap between back-to-back frames
        chk(gap_bad == 0, "R11", 64'(gap_bad), 64'd0);

        // R4: PHY numbers beyond the populated range
        f0 = frames;
        for (int p = NUM_PHY; p < 32; p++) begin
            w = mk_cmd(1, 1, p[0], p, 31 - p, 16'(p * 16'h0101));
            issue(w);
            chk(csr_rdata == mk_cmd(0, 1, p[0], p, 31 - p, 16'(p * 16'h0101)), "R4",
                64'(csr_rdata), 64'(mk_cmd(0, 1, p[0], p, 31 - p, 16'(p * 16'h0101))));
        end
        // R5: enable or busy flag missing
        for (int m = 0; m < 3; m++) begin
            w = mk_cmd(m != 0, m == 0, 0, m, m, 16'hBEEF);
            issue(w);
            chk(csr_rdata[31] == 1'b0, "R5", 64'(csr_rdata), 64'(w & 32'h7FFF_FFFF));
        end
        repeat (MDC_DIV * 80) @(negedge clk);
        chk(frames == f0 && !in_frame, "R4", 64'(frames), 64'(f0));

        // R9: write while busy is ignored
        cur_rd = 1'b0;
        w = mk_cmd(1, 1, 0, 2, 9, 16'hC0DE);
        issue(w);
        repeat (40) @(negedge clk);
        snap = csr_rdata;
        issue(mk_cmd(1, 1, 1, 4, 3, 16'h1111));
        chk(csr_rdata == snap, "R9", 64'(csr_rdata), 64'(snap));
        wait_idle();
        chk(cap_o == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd9, 2'b10, 16'hC0DE}, "R9",
            cap_o, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd9, 2'b10, 16'hC0DE});

        // R9: write held through the cycle busy clears
        cur_rd = 1'b1;
        rd_val = phy_val(1, 17);
        issue(mk_cmd(1, 1, 1, 1, 17, 16'h0000));
        b_cmd = mk_cmd(0, 0, 0, 3, 6, 16'h7E57);
        @(negedge clk);
        csr_wr = 1'b1;
        csr_wdata = b_cmd;
        for (int n = 0; n < 2000 && csr_rdata[31]; n++) @(negedge clk);
        chk(csr_rdata == mk_cmd(0, 1, 1, 1, 17, phy_val(1, 17)), "R9",
            64'(csr_rdata), 64'(mk_cmd(0, 1, 1, 1, 17, phy_val(1, 17))));
        @(negedge clk);
        csr_wr = 1'b0;
        chk(csr_rdata == b_cmd, "R9", 64'(csr_rdata), 64'(b_cmd));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule